// File: doc/BRIEF.md
# DRAM Strobe and Wait-State Generator

This block sits between an 8-bit processor bus and asynchronous DRAM. It watches the processor's active-low memory-request, opcode-fetch, refresh, read and write strobes together with the CPU clock. From them it produces the DRAM row strobe, the column strobe, a select for the external row/column address multiplexer, and an active-low WAIT. WAIT lengthens each opcode fetch by a set number of clocks.

Each memory cycle starts its row strobe on the first rising clock edge that finds the request active. The column address and the column strobe follow on later falling edges. Refresh cycles use a row-only pulse on the refresh address that the processor drives, with the column strobe held off.

Rising-edge events and falling-edge events come from two register banks, one clocked on each edge. A two-flop parity token carries the row-strobe state between the banks, so every strobe changes only at a defined edge or when the request is withdrawn.

Top module: `dram_strobe_gen`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and wait_n are 1 and mux_col is 0, whatever the bus strobes do.
- R2: ras_n goes to 0 on the first rising clock edge at which mreq_n is 0, and not before that edge.
- R3: In a fetch (m1_n=0) or read (rd_n=0) cycle, cas_n goes to 0 and mux_col goes to 1 on the first falling edge after ras_n went to 0.
- R4: In a write cycle, mux_col goes to 1 on the first falling edge after ras_n went to 0, and cas_n goes to 0 only on the first falling edge that finds wr_n at 0.
- R5: In a fetch cycle wait_n goes to 0 on the same rising edge as ras_n, and returns to 1 after exactly WAIT_CLKS rising edges (default 1), even while m1_n stays 0.
- R6: Read, write and refresh cycles leave wait_n at 1.
- R7: A cycle that has rfsh_n at 0 when its row strobe starts is a refresh. ras_n goes to 0 on the first rising edge with mreq_n and rfsh_n both 0, and stays there while mreq_n is 0. cas_n stays 1 and mux_col stays 0.
- R8: When mreq_n returns to 1, ras_n, cas_n and wait_n return to 1 and mux_col to 0 at once, without waiting for a clock edge.
- R9: A request that starts in the same clock in which the previous one ended is taken as a new cycle: ras_n stays 1 until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| mreq_n | input | 1 | Memory request, active low |
| m1_n | input | 1 | Opcode fetch marker, active low |
| rfsh_n | input | 1 | Refresh marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ras_n | output | 1 | DRAM row address strobe, active low |
| cas_n | output | 1 | DRAM column address strobe, active low |
| mux_col | output | 1 | 1 selects the column address, 0 the row address |
| wait_n | output | 1 | Wait request to the processor, active low |

## Verification
The row strobe and WAIT are due on the first rising edge after the request appears, and the column strobe and column select on the falling edge half a clock later. For writes the column strobe is due one clock later still, and the end of WAIT falls WAIT_CLKS rising edges after its start. Release is due with no edge at all. Each scenario task drives the bus two nanoseconds after an edge and samples three nanoseconds after the edge at which a result is due. It checks the value one sample before as well, so an early or late change is caught. The release checks sample one nanosecond after mreq_n rises, before any edge can act.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_PEND,
    CYC_FETCH,
    CYC_READ,
    CYC_WRITE,
    CYC_REFRESH
  } cyc_kind_t;
endpackage

// File: rtl/dstrb_reset_sync.sv
module dstrb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dstrb_decode.sv
module dstrb_decode
  import dram_strobe_pkg::*;
(
  input  logic      mreq_n,
  input  logic      m1_n,
  input  logic      rfsh_n,
  input  logic      rd_n,
  input  logic      wr_n,
  output logic      mreq_act,
  output cyc_kind_t kind
);
  always_comb begin
    mreq_act = ~mreq_n;
    if (mreq_n)       kind = CYC_IDLE;
    else if (!rfsh_n) kind = CYC_REFRESH;
    else if (!m1_n)   kind = CYC_FETCH;
    else if (!rd_n)   kind = CYC_READ;
    else if (!wr_n)   kind = CYC_WRITE;
    else              kind = CYC_PEND;
  end
endmodule

// File: rtl/dstrb_rise.sv
module dstrb_rise
  import dram_strobe_pkg::*;
#(
  parameter int WAIT_CLKS = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mreq_act,
  input  cyc_kind_t kind,
  input  logic      ras_state,
  input  logic      fall_tok,
  output logic      rise_tok,
  output logic      rfsh_q,
  output logic      wait_q
);
  localparam int CW = $clog2(WAIT_CLKS + 2);

  logic          first;
  logic          tok_nxt, rfsh_nxt, wait_nxt, cnt_en;
  logic [CW-1:0] cnt_q, cnt_nxt;

  // a new cycle: request active while the row strobe state is clear
  always_comb begin
    first    = mreq_act & ~ras_state;
    tok_nxt  = first ? ~fall_tok : rise_tok;
    rfsh_nxt = first ? (kind == CYC_REFRESH) : rfsh_q;
    if (first && kind == CYC_FETCH) cnt_nxt = CW'(WAIT_CLKS);
    else if (cnt_q != '0)           cnt_nxt = cnt_q - CW'(1);
    else                            cnt_nxt = '0;
    wait_nxt = (cnt_nxt != '0);
    cnt_en   = first | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_tok <= 1'b0;
      rfsh_q   <= 1'b0;
      cnt_q    <= '0;
      wait_q   <= 1'b0;
    end else if (cnt_en) begin
      rise_tok <= tok_nxt;
      rfsh_q   <= rfsh_nxt;
      cnt_q    <= cnt_nxt;
      wait_q   <= wait_nxt;
    end
  end
endmodule

// File: rtl/dstrb_fall.sv
module dstrb_fall
  import dram_strobe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mreq_act,
  input  cyc_kind_t kind,
  input  logic      ras_state,
  input  logic      rfsh_q,
  input  logic      rise_tok,
  output logic      fall_tok,
  output logic      cas_q,
  output logic      mux_q
);
  logic access, strobe_ok;
  logic tok_nxt, cas_nxt, mux_nxt;

  always_comb begin
    access    = ras_state & mreq_act & ~rfsh_q;
    strobe_ok = (kind == CYC_FETCH) | (kind == CYC_READ) | (kind == CYC_WRITE);
    // an idle falling edge closes the row strobe state
    tok_nxt   = mreq_act ? fall_tok : rise_tok;
    mux_nxt   = mreq_act & (mux_q | access);
    cas_nxt   = mreq_act & (cas_q | (access & strobe_ok));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_tok <= 1'b0;
      cas_q    <= 1'b0;
      mux_q    <= 1'b0;
    end else begin
      fall_tok <= tok_nxt;
      cas_q    <= cas_nxt;
      mux_q    <= mux_nxt;
    end
  end
endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
  import dram_strobe_pkg::*;
#(
  parameter int WAIT_CLKS   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mreq_n,
  input  logic m1_n,
  input  logic rfsh_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic ras_n,
  output logic cas_n,
  output logic mux_col,
  output logic wait_n
);
  logic      rst_sync_n;
  logic      mreq_act;
  cyc_kind_t kind;
  logic      rise_tok, fall_tok, ras_state;
  logic      rfsh_q, wait_q, cas_q, mux_q;

  dstrb_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dstrb_decode u_dec (
    .mreq_n(mreq_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .rd_n(rd_n), .wr_n(wr_n),
    .mreq_act(mreq_act), .kind(kind)
  );

  // parity of two single-edge flops: each edge bank flips only its own
  assign ras_state = rise_tok ^ fall_tok;

  dstrb_rise #(.WAIT_CLKS(WAIT_CLKS)) u_rise (
    .clk(clk), .rst_n(rst_sync_n), .mreq_act(mreq_act), .kind(kind),
    .ras_state(ras_state), .fall_tok(fall_tok), .rise_tok(rise_tok),
    .rfsh_q(rfsh_q), .wait_q(wait_q)
  );

  dstrb_fall u_fall (
    .clk(clk), .rst_n(rst_sync_n), .mreq_act(mreq_act), .kind(kind),
    .ras_state(ras_state), .rfsh_q(rfsh_q), .rise_tok(rise_tok),
    .fall_tok(fall_tok), .cas_q(cas_q), .mux_q(mux_q)
  );

  assign ras_n   = ~(ras_state & mreq_act);
  assign cas_n   = ~(cas_q & mreq_act);
  assign mux_col = mux_q & mreq_act;
  assign wait_n  = ~(wait_q & mreq_act);
endmodule

// File: rtl/dram_strobe_chk.sv
module dram_strobe_chk #(
  parameter int WAIT_CLKS = 1
) (
  input logic clk,
  input logic rst_n,
  input logic mreq_n,
  input logic m1_n,
  input logic rfsh_n,
  input logic rd_n,
  input logic wr_n,
  input logic ras_n,
  input logic cas_n,
  input logic mux_col,
  input logic wait_n
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= '0;
    else if (!wait_n) low_run <= low_run + 16'd1;
    else              low_run <= '0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (ras_n && cas_n && wait_n && !mux_col)
        else $error("strobes active during reset");
    end
  end

  assert_ras_needs_req_R2: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !mreq_n);

  assert_cas_after_ras_R3: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !ras_n);

  assert_wait_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 16'(WAIT_CLKS));

  assert_wait_fetch_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_n) |-> !m1_n);

  assert_refresh_no_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rfsh_n && !mreq_n) |-> (cas_n && !mux_col));

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (ras_n && cas_n && wait_n && !mux_col));

  logic unused_ok;
  assign unused_ok = rd_n ^ wr_n;
endmodule

bind dram_strobe_gen dram_strobe_chk #(.WAIT_CLKS(WAIT_CLKS)) u_chk (.*);

// File: tb/dram_strobe_gen_test.sv
module dram_strobe_gen_test;
  logic clk = 1'b0;
  logic rst_n, mreq_n, m1_n, rfsh_n, rd_n, wr_n;
  logic ras_n, cas_n, mux_col, wait_n;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dram_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .m1_n(m1_n), .rfsh_n(rfsh_n),
    .rd_n(rd_n), .wr_n(wr_n), .ras_n(ras_n), .cas_n(cas_n),
    .mux_col(mux_col), .wait_n(wait_n)
  );

  // expected vector order: ras_n, cas_n, mux_col, wait_n
  task automatic expect_out(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ras_n, cas_n, mux_col, wait_n};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: ras/cas/mux/wait actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_idle();
    mreq_n = 1; m1_n = 1; rfsh_n = 1; rd_n = 1; wr_n = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; bus_idle();
    repeat (2) @(posedge clk);
    #2 mreq_n = 0; m1_n = 0;
    @(posedge clk); #3 expect_out("R1", 4'b1101);
    @(negedge clk); #3 expect_out("R1", 4'b1101);
    bus_idle();
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
  endtask

  // fetch, then refresh that starts in the clock where the fetch ends
  task automatic t_fetch_refresh();
    @(posedge clk); #2 m1_n = 0;
    @(negedge clk); #2 mreq_n = 0; rd_n = 0;
    #3 expect_out("R2", 4'b1101);
    @(posedge clk); #3 expect_out("R5", 4'b0100);
    @(negedge clk); #3 expect_out("R3", 4'b0010);
    @(posedge clk); #3 expect_out("R5", 4'b0011);
    @(negedge clk); #3 expect_out("R5", 4'b0011);
    @(posedge clk); #2 mreq_n = 1; rd_n = 1; m1_n = 1; rfsh_n = 0;
    #1 expect_out("R8", 4'b1101);
    @(negedge clk); #2 mreq_n = 0;
    #3 expect_out("R9", 4'b1101);
    @(posedge clk); #3 expect_out("R7", 4'b0101);
    @(negedge clk); #3 expect_out("R7", 4'b0101);
    @(posedge clk); #3 expect_out("R7", 4'b0101);
    @(negedge clk); #2 mreq_n = 1;
    #1 expect_out("R8", 4'b1101);
    @(posedge clk); #2 rfsh_n = 1;
  endtask

  task automatic t_read();
    @(posedge clk); #2;
    @(negedge clk); #2 mreq_n = 0; rd_n = 0;
    @(posedge clk); #3 expect_out("R6", 4'b0101);
    @(negedge clk); #3 expect_out("R3", 4'b0011);
    @(posedge clk); #3 expect_out("R6", 4'b0011);
    @(negedge clk); #2 mreq_n = 1; rd_n = 1;
    #1 expect_out("R8", 4'b1101);
  endtask

  task automatic t_write();
    @(posedge clk); #2;
    @(negedge clk); #2 mreq_n = 0;
    @(posedge clk); #3 expect_out("R6", 4'b0101);
    @(negedge clk); #2 wr_n = 0;
    #1 expect_out("R4", 4'b0111);
    @(posedge clk); #3 expect_out("R4", 4'b0111);
    @(negedge clk); #3 expect_out("R4", 4'b0011);
    #2 mreq_n = 1; wr_n = 1;
    #1 expect_out("R8", 4'b1101);
  endtask

  initial begin
    t_reset();
    t_fetch_refresh();
    t_read();
    t_write();
    t_fetch_refresh();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule